// File: doc/BRIEF.md
# Interleaved Processor/Video DRAM Slot Arbiter

This block shares one dynamic RAM array between a processor and a video scan address source. It does not arbitrate by request. A phase counter running on a fast reference clock splits time into fixed slots, and ownership of the RAM alternates between the video side and the processor side on every slot. Inside each slot the block drives the row half of the owner's address, pulls the row strobe low, switches the multiplexed bus to the column half, and then opens the column strobe of the selected bank. On a read it captures the returned byte into the owner's read register in the last phase in which the column strobe is open.

The block has no refresh counter. The row strobe falls once in every slot whether or not the processor wants the RAM, and the video scan walks sequential addresses. Because the row is taken from the low address bits, the video slots alone revisit every row well inside the retention limit. The `cpu_slot` output tells the processor clocking logic which side owns the current slot, so that it can stretch or align its cycle. A parameter selects one bank (16 KB) or two banks (32 KB) of by-one devices.

Top module: `dram_slot_arbiter`

## Requirements
- R1: During reset `cpu_slot` is 0, both column strobes and the write strobe are high (inactive), and both read registers hold 0. After reset the first slot belongs to the video side.
- R2: Slot ownership alternates. `cpu_slot` is 1 for PHASES cycles and then 0 for PHASES cycles, and it changes only at the start of a slot.
- R3: The row strobe `dram_ras_n` is low in phases 0 to PHASES-2 and high in phase PHASES-1 of every slot. This holds regardless of processor requests.
- R4: `dram_addr` carries the row (address bits [6:0]) in phase 0 and the column (address bits [13:7]) in all later phases of the slot.
- R5: A column strobe is low only in phases 2 to PHASES-2, and only for an active in-range access. `dram_cas_n[0]` serves addresses with bit 14 clear and `dram_cas_n[1]` serves addresses with bit 14 set. At most one column strobe is low at a time, and only while the row strobe is low.
- R6: `dram_we_n` is low only in a processor slot whose latched request has `cpu_sel`=1 and `cpu_we`=1 and an in-range address, in phases 1 to PHASES-2. While it is low, `dram_dq_o` carries the latched write byte. Video slots never write.
- R7: For a processor read, `cpu_rdata` loads the bus byte at the clock edge that ends phase PHASES-2 of the processor slot. Otherwise it holds its value, and it never changes during a video slot.
- R8: In every video slot, `vid_rdata` loads the byte for the latched video address at the edge that ends phase PHASES-2.
- R9: With EXPANDED=0, an address with bit 14 set opens no column strobe and no write strobe, reads as 8'hFF, and leaves memory unchanged.
- R10: The owner's address, select, write flag and write byte are sampled only at the edge that ends the last phase of the preceding slot. Changes to the inputs during a slot have no effect on that slot.
- R11: With a video scan that advances by one address per video slot, every one of the 128 row indices receives a row-strobe falling edge with its row address present within a window of 1100 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Processor requests RAM in its next slot |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | 15 | Processor byte address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Last byte read for the processor |
| vid_addr | input | 15 | Video scan address |
| vid_rdata | output | 8 | Last byte read for the video path |
| cpu_slot | output | 1 | 1 while the current slot belongs to the processor |
| dram_addr | output | 7 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, shared by both banks |
| dram_cas_n | output | 2 | Column strobe per bank |
| dram_we_n | output | 1 | Write strobe |
| dram_dq_o | output | 8 | Write data to the array |
| dram_dq_i | input | 8 | Read data from the array |

## Verification
The embedded properties check several rules on every cycle. The row strobe is never high for more than one cycle. Ownership changes only where a row strobe falls. Column strobes stay exclusive and inside the row strobe. Writes appear only in processor slots. The processor read register stays frozen through video slots. Whether the right byte lands in the right read register, whether a write to the absent bank is ignored, whether mid-slot input changes are ignored, and whether the video scan covers all rows in time can only be shown by the bench. It runs a behavioural array model and a reference model for both bank configurations.

// File: rtl/dram_slot_arbiter.sv
module dram_slot_arbiter #(
  parameter int EXPANDED = 1,
  parameter int PHASES   = 4,
  parameter int ROW_W    = 7,
  parameter int COL_W    = 7,
  parameter int DATA_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_sel,
  input  logic                     cpu_we,
  input  logic [ROW_W+COL_W:0]     cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  output logic [DATA_W-1:0]        cpu_rdata,
  input  logic [ROW_W+COL_W:0]     vid_addr,
  output logic [DATA_W-1:0]        vid_rdata,
  output logic                     cpu_slot,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic                     dram_ras_n,
  output logic [1:0]               dram_cas_n,
  output logic                     dram_we_n,
  output logic [DATA_W-1:0]        dram_dq_o,
  input  logic [DATA_W-1:0]        dram_dq_i
);
  localparam int AW    = ROW_W + COL_W + 1;
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int PH_W  = $clog2(PHASES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0] PH_CAP  = PH_W'(PHASES - 2);
  localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);
  localparam logic [PH_W-1:0] PH_TWO  = PH_W'(2);

  logic [PH_W-1:0]   phase;
  logic              slot;
  logic [AW-1:0]     cur_addr;
  logic              cur_act, cur_we;
  logic [DATA_W-1:0] cur_wd;

  wire last     = (phase == PH_LAST);
  wire cap      = (phase == PH_CAP);
  wire bank     = cur_addr[AW-1];
  wire in_range = (EXPANDED != 0) || !bank;
  wire go       = cur_act && in_range;
  wire cas_win  = (phase >= PH_TWO) && (phase <= PH_CAP);
  wire wr_win   = (phase >= PH_ONE) && (phase <= PH_CAP);
  wire [DATA_W-1:0] rd_byte = in_range ? dram_dq_i : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      slot      <= 1'b0;
      cur_addr  <= '0;
      cur_act   <= 1'b1;
      cur_we    <= 1'b0;
      cur_wd    <= '0;
      cpu_rdata <= '0;
      vid_rdata <= '0;
    end else begin
      phase <= last ? '0 : phase + PH_ONE;
      if (last) begin
        slot <= ~slot;
        if (!slot) begin
          cur_addr <= cpu_addr;
          cur_act  <= cpu_sel;
          cur_we   <= cpu_we;
          cur_wd   <= cpu_wdata;
        end else begin
          cur_addr <= vid_addr;
          cur_act  <= 1'b1;
          cur_we   <= 1'b0;
          cur_wd   <= '0;
        end
      end
      if (cap && cur_act && !cur_we) begin
        if (slot) cpu_rdata <= rd_byte;
        else      vid_rdata <= rd_byte;
      end
    end
  end

  assign cpu_slot      = slot;
  assign dram_ras_n    = last;
  assign dram_addr     = (phase == '0) ? MUX_W'(cur_addr[ROW_W-1:0])
                                       : MUX_W'(cur_addr[ROW_W+COL_W-1:ROW_W]);
  assign dram_cas_n[0] = !(go && cas_win && !bank);
  assign dram_cas_n[1] = !(go && cas_win && bank);
  assign dram_we_n     = !(slot && go && cur_we && wr_win);
  assign dram_dq_o     = cur_wd;

  // R3
  ras_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |=> $fell(dram_ras_n));
  // R2
  slot_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpu_slot) |-> $fell(dram_ras_n));
  // R5
  cas_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dram_cas_n) <= 1);
  // R5
  cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas_n != 2'b11) |-> !dram_ras_n);
  // R6
  we_cpu_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> cpu_slot);
  // R7
  cpu_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_slot |-> $stable(cpu_rdata));
endmodule

// File: tb/dram_slot_arbiter_tb.sv
module dram_slot_arbiter_lane #(parameter int EXP = 1) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_sel,
  input  logic        cpu_we,
  input  logic [14:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic [14:0] vid_addr,
  output logic [7:0]  cpu_rdata,
  output logic        cpu_slot,
  output int          n_cmp,
  output int          n_bad
);
  localparam int P = 4;
  logic [7:0] vid_rdata, dq_o, dq_i;
  logic [6:0] d_addr;
  logic       ras_n, we_n;
  logic [1:0] cas_n;

  dram_slot_arbiter #(.EXPANDED(EXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .vid_addr(vid_addr), .vid_rdata(vid_rdata), .cpu_slot(cpu_slot),
    .dram_addr(d_addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_dq_o(dq_o), .dram_dq_i(dq_i));

  logic [7:0] dmem [32768];
  logic [7:0] rmem [32768];
  bit         seen [128];
  logic [6:0] row_q = '0;
  logic       ras_prev = 1'b1;
  logic [1:0] cas_prev = 2'b11;

  function automatic logic [7:0] init_val(int a);
    return 8'(a * 7 + (a >> 8));
  endfunction

  initial begin
    n_cmp = 0; n_bad = 0;
    for (int i = 0; i < 32768; i++) begin dmem[i] = init_val(i); rmem[i] = init_val(i); end
    for (int i = 0; i < 128; i++) seen[i] = 1'b0;
  end

  always_comb begin
    if (!cas_n[0])      dq_i = dmem[{1'b0, d_addr, row_q}];
    else if (!cas_n[1]) dq_i = dmem[{1'b1, d_addr, row_q}];
    else                dq_i = 8'hA5;
  end

  always @(posedge clk) begin
    if (ras_prev && !ras_n) begin row_q <= d_addr; seen[d_addr] = 1'b1; end
    for (int b = 0; b < 2; b++)
      if (!we_n && !cas_n[b] && cas_prev[b]) dmem[{b[0], d_addr, row_q}] = dq_o;
    ras_prev <= ras_n;
    cas_prev <= cas_n;
  end

  task automatic clear_seen();
    for (int i = 0; i < 128; i++) seen[i] = 1'b0;
  endtask

  function automatic int count_seen();
    int n = 0;
    for (int i = 0; i < 128; i++) if (seen[i]) n++;
    return n;
  endfunction

  int         m_phase;
  bit         m_slot, m_act, m_we, started = 0;
  logic [14:0] m_addr;
  logic [7:0] m_wd, m_cpu, m_vid;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_phase = 0; m_slot = 0; m_addr = '0; m_act = 1; m_we = 0; m_wd = '0;
      m_cpu = '0; m_vid = '0;
    end else begin
      bit inr;
      inr = (EXP != 0) || !m_addr[14];
      if (m_phase == P-2 && m_act) begin
        if (m_we && m_slot) begin
          if (inr) rmem[m_addr] = m_wd;
        end else begin
          if (m_slot) m_cpu = inr ? rmem[m_addr] : 8'hFF;
          else        m_vid = inr ? rmem[m_addr] : 8'hFF;
        end
      end
      if (m_phase == P-1) begin
        m_phase = 0;
        if (!m_slot) begin m_addr = cpu_addr; m_act = cpu_sel; m_we = cpu_we; m_wd = cpu_wdata; end
        else begin m_addr = vid_addr; m_act = 1; m_we = 0; m_wd = '0; end
        m_slot = !m_slot;
      end else m_phase++;
    end
  end

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s lane EXP=%0d actual=%h expected=%h at %0t", tag, EXP, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    bit inr, go, cw, bk;
    inr = (EXP != 0) || !m_addr[14];
    go  = m_act && inr;
    bk  = (EXP != 0) && m_addr[14];
    cw  = go && m_phase >= 2 && m_phase <= P-2;
    cmp("R2 cpu_slot", 16'(cpu_slot), 16'(m_slot));
    cmp("R3 ras", 16'(ras_n), 16'(m_phase == P-1));
    cmp("R4/R10 addr", 16'(d_addr), (m_phase == 0) ? 16'(m_addr[6:0]) : 16'(m_addr[13:7]));
    cmp("R5/R9 cas", 16'(cas_n), 16'({!(cw && bk), !(cw && !bk)}));
    cmp("R6/R9 we", 16'(we_n), 16'(!(m_slot && go && m_we && m_phase >= 1 && m_phase <= P-2)));
    if (!we_n) cmp("R6 wdata", 16'(dq_o), 16'(m_wd));
    cmp("R7 cpu_rdata", 16'(cpu_rdata), 16'(m_cpu));
    cmp("R8 vid_rdata", 16'(vid_rdata), 16'(m_vid));
  end
endmodule

module dram_slot_arbiter_tb;
  logic clk = 0, rst_n = 0, cpu_sel = 0, cpu_we = 0;
  logic [14:0] cpu_addr = '0, vid_addr = '0;
  logic [7:0]  cpu_wdata = '0, rd_x, rd_b;
  logic        slot_x, slot_b, done = 0;
  int cx, bx, cb, bb, n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  dram_slot_arbiter_lane #(.EXP(1)) u_dut (.clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .vid_addr(vid_addr),
    .cpu_rdata(rd_x), .cpu_slot(slot_x), .n_cmp(cx), .n_bad(bx));
  dram_slot_arbiter_lane #(.EXP(0)) u_base (.clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .vid_addr(vid_addr),
    .cpu_rdata(rd_b), .cpu_slot(slot_b), .n_cmp(cb), .n_bad(bb));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic cpu_op(logic [14:0] a, logic w, logic [7:0] d);
    @(negedge clk); cpu_sel = 1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    repeat (8) @(negedge clk);
    cpu_sel = 0; cpu_we = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + cx + cb, n_bad + bx + bb);
      $finish;
    end
  endtask

  initial begin
    forever begin
      repeat (8) @(negedge clk);
      vid_addr = vid_addr + 15'd1;
    end
  end

  initial begin
    #(150000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check("R1 slot", 16'(slot_x), 16'd0);
    check("R1 rdata", 16'(rd_x), 16'd0);
    check("R1 rdata base", 16'(rd_b), 16'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 first slot video", 16'(slot_x), 16'd0);

    cpu_op(15'h0123, 1, 8'h3C);
    cpu_op(15'h4123, 1, 8'hC3);
    cpu_op(15'h0123, 0, 8'h00);
    // R7 read back after write
    check("R7 read bank0", 16'(rd_x), 16'h3C);
    check("R7 read bank0 base", 16'(rd_b), 16'h3C);
    cpu_op(15'h4123, 0, 8'h00);
    // R5 upper bank in expanded build; R9 reads all ones in base build
    check("R5 read bank1", 16'(rd_x), 16'hC3);
    check("R9 base upper reads FF", 16'(rd_b), 16'hFF);
    cpu_op(15'h0123, 0, 8'h00);
    check("R9 ignored write did not alias", 16'(rd_b), 16'h3C);
    cpu_op(15'h7FFF, 1, 8'h81);
    cpu_op(15'h7FFF, 0, 8'h00);
    check("R5 top address", 16'(rd_x), 16'h81);
    check("R9 top address base", 16'(rd_b), 16'hFF);

    // R10: inputs toggling every cycle, including inside slots
    begin
      logic [31:0] s = 32'h1234_5678;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        s = s * 32'd1664525 + 32'd1013904223;
        cpu_sel = s[31]; cpu_we = s[30]; cpu_addr = s[22:8]; cpu_wdata = s[7:0];
      end
      cpu_sel = 0; cpu_we = 0;
    end

    // R11: refresh coverage by the sequential video scan alone, processor idle (R3)
    @(negedge clk);
    u_dut.clear_seen(); u_base.clear_seen();
    repeat (1100) @(negedge clk);
    check("R11 rows refreshed", 16'(u_dut.count_seen()), 16'd128);
    check("R11 rows refreshed base", 16'(u_base.count_seen()), 16'd128);

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule